// File: doc/BRIEF.md
# Reload-Counter Synchronous Serial Port

This block is the host side of a byte-wide synchronous serial link. It builds its serial clock from a down-counter that runs on the system clock. Each time the counter reaches zero, the serial clock output toggles and the counter loads again from a programmed value. A reload value N gives half a bit period of N+1 system clocks. A reload value of zero is counted as 256, so the slowest setting gives a 257-clock half period.

Software-side logic writes two registers through a small write port: the reload value and the byte to send. A one-cycle start pulse then launches a transfer. Eight bits go out most significant bit first. Each bit is presented while the serial clock is low and the inbound line is sampled on each rising clock edge. After the sixteenth clock toggle the serial clock rests low, a done level rises, and the received byte appears on a parallel output.

Top module: `reload_serial_port`

## Requirements
- R1: After reset, sclk_o, sdo_o, busy_o and done_o are 0 and rx_data_o is all zeros.
- R2: With a reload value N in 1..255, every half period of sclk_o lasts N+1 system clocks, and the first rising edge comes N+1 clocks after the clock edge that accepted start. N=1 gives a 4-clock bit.
- R3: A reload value of 0 is counted as 256, so every half period lasts 257 system clocks.
- R4: Bits leave on sdo_o most significant first. The first bit appears when the transfer is accepted, and sdo_o changes only when sclk_o falls, never while it is high or as it rises.
- R5: sdi_i is sampled at each rising edge of sclk_o, most significant bit first. The assembled byte is placed on rx_data_o when the transfer ends, and rx_data_o stays unchanged while busy_o is high.
- R6: A transfer ends on the eighth falling edge of sclk_o (the sixteenth toggle). On that clock edge busy_o drops, sclk_o rests at 0 and done_o rises. done_o stays high until the next accepted start clears it, and sclk_o is always 0 when busy_o is 0.
- R7: A reload value written during a transfer leaves the half period in progress unchanged and applies from the next counter reload.
- R8: A start pulse while busy_o is high is ignored. The running transfer keeps its timing and data, and no second transfer follows.
- R9: Writing the transmit register during a transfer does not alter the bits being sent, because the byte is captured when start is accepted. The write port selects the reload register with wr_sel_i=0 and the transmit register with wr_sel_i=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0 selects the reload register, 1 selects the transmit register |
| wr_data_i | input | DATA_W | Write data; the reload register takes the low CNT_W bits |
| start_i | input | 1 | One-cycle request to begin a transfer |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Last transfer finished; cleared by the next accepted start |
| rx_data_o | output | DATA_W | Byte received by the last transfer |
| sclk_o | output | 1 | Serial clock, idle low |
| sdo_o | output | 1 | Serial data out |
| sdi_i | input | 1 | Serial data in |

## Verification
Faults in the reload counter show up within the first half period as a wrong distance from start to the first sclk_o edge or between later edges. The bench times every edge of every transfer to the exact clock, so one extra or missing count is seen immediately. A fault in the toggle counter or the shift registers shows up at the end of the byte, either as a transfer ending one edge early or late or as wrong bits. The bench compares the bits captured on sdo_o at each rising edge, and the byte that arrives on rx_data_o, against a scoreboard entry. A start pulse or register write during a transfer that leaks into the running state shows up as a restarted clock or an extra unexpected transfer in that same byte.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

   // Register selector on the write port
   typedef enum logic {
      SEL_RELOAD = 1'b0,
      SEL_TXBYTE = 1'b1
   } ssp_sel_e;

   // Event set produced by the sequencer for the data path
   typedef struct packed {
      logic launch;
      logic rise;
      logic fall;
      logic last;
   } ssp_evt_t;

endpackage

// File: rtl/ssp_config_regs.sv
module ssp_config_regs
   import ssp_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int CNT_W        = 8,
   parameter int RESET_RELOAD = 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic              wr_sel_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic [CNT_W-1:0]  reload_o,
   output logic [DATA_W-1:0] txbyte_o
);

   ssp_sel_e sel;
   assign sel = ssp_sel_e'(wr_sel_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         reload_o <= CNT_W'(RESET_RELOAD);
         txbyte_o <= '0;
      end else if (wr_en_i) begin
         if (sel == SEL_RELOAD) reload_o <= wr_data_i[CNT_W-1:0];
         else                   txbyte_o <= wr_data_i;
      end
   end

endmodule

// File: rtl/ssp_reload_timer.sv
module ssp_reload_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             launch_i,
   input  logic             run_i,
   input  logic [CNT_W-1:0] reload_i,
   output logic             tick_o
);

   localparam int LW = CNT_W + 1;
   localparam logic [LW-1:0] ZERO_AS = LW'(1) << CNT_W;

   logic [LW-1:0] count_q;
   logic [LW-1:0] load_val;

   // a programmed zero counts as the full 2**CNT_W span
   assign load_val = (reload_i == '0) ? ZERO_AS : {1'b0, reload_i};
   assign tick_o   = run_i && (count_q == '0);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         count_q <= '0;
      end else if (launch_i) begin
         count_q <= load_val;
      end else if (run_i) begin
         if (count_q == '0) count_q <= load_val;
         else               count_q <= count_q - LW'(1);
      end
   end

endmodule

// File: rtl/ssp_sequencer.sv
module ssp_sequencer
   import ssp_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic     clk_i,
   input  logic     rst_ni,
   input  logic     start_i,
   input  logic     tick_i,
   output logic     busy_o,
   output logic     done_o,
   output logic     sclk_o,
   output ssp_evt_t evt_o
);

   localparam int EDGES = 2 * DATA_W;
   localparam int EW    = $clog2(EDGES);

   logic [EW-1:0] edge_q;
   logic          launch;
   logic          last_edge;

   assign launch    = start_i && !busy_o;
   assign last_edge = tick_i && sclk_o && (edge_q == EW'(EDGES - 1));

   assign evt_o.launch = launch;
   assign evt_o.rise   = tick_i && !sclk_o;
   assign evt_o.fall   = tick_i && sclk_o;
   assign evt_o.last   = last_edge;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         busy_o <= 1'b0;
         done_o <= 1'b0;
         sclk_o <= 1'b0;
         edge_q <= '0;
      end else if (launch) begin
         busy_o <= 1'b1;
         done_o <= 1'b0;
         sclk_o <= 1'b0;
         edge_q <= '0;
      end else if (tick_i) begin
         if (last_edge) begin
            busy_o <= 1'b0;
            done_o <= 1'b1;
            sclk_o <= 1'b0;
            edge_q <= '0;
         end else begin
            sclk_o <= ~sclk_o;
            edge_q <= edge_q + EW'(1);
         end
      end
   end

endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter
   import ssp_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  ssp_evt_t          evt_i,
   input  logic [DATA_W-1:0] txbyte_i,
   input  logic              sdi_i,
   output logic              sdo_o,
   output logic [DATA_W-1:0] rx_data_o
);

   logic [DATA_W-1:0] tx_q;
   logic [DATA_W-1:0] rx_q;

   assign sdo_o = tx_q[DATA_W-1];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         tx_q      <= '0;
         rx_q      <= '0;
         rx_data_o <= '0;
      end else if (evt_i.launch) begin
         tx_q <= txbyte_i;
         rx_q <= '0;
      end else begin
         if (evt_i.rise) rx_q <= {rx_q[DATA_W-2:0], sdi_i};
         if (evt_i.fall && !evt_i.last) tx_q <= {tx_q[DATA_W-2:0], 1'b0};
         if (evt_i.last) rx_data_o <= rx_q;
      end
   end

endmodule

// File: rtl/reload_serial_port.sv
module reload_serial_port
   import ssp_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int CNT_W        = 8,
   parameter int RESET_RELOAD = 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic              wr_sel_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              start_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [DATA_W-1:0] rx_data_o,
   output logic              sclk_o,
   output logic              sdo_o,
   input  logic              sdi_i
);

   if (DATA_W < 2) begin : g_bad_data_w
      $error("reload_serial_port: DATA_W must be at least 2");
   end
   if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cnt_w
      $error("reload_serial_port: CNT_W must lie in 1..DATA_W");
   end
   if (RESET_RELOAD < 0 || RESET_RELOAD >= (1 << CNT_W)) begin : g_bad_reset
      $error("reload_serial_port: RESET_RELOAD out of range");
   end

   logic [CNT_W-1:0]  reload;
   logic [DATA_W-1:0] txbyte;
   logic              tick;
   ssp_evt_t          evt;

   ssp_config_regs #(
      .DATA_W       (DATA_W),
      .CNT_W        (CNT_W),
      .RESET_RELOAD (RESET_RELOAD)
   ) regs_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en_i),
      .wr_sel_i  (wr_sel_i),
      .wr_data_i (wr_data_i),
      .reload_o  (reload),
      .txbyte_o  (txbyte)
   );

   ssp_reload_timer #(
      .CNT_W (CNT_W)
   ) timer_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .launch_i (evt.launch),
      .run_i    (busy_o),
      .reload_i (reload),
      .tick_o   (tick)
   );

   ssp_sequencer #(
      .DATA_W (DATA_W)
   ) seq_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (start_i),
      .tick_i  (tick),
      .busy_o  (busy_o),
      .done_o  (done_o),
      .sclk_o  (sclk_o),
      .evt_o   (evt)
   );

   ssp_shifter #(
      .DATA_W (DATA_W)
   ) shift_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .evt_i     (evt),
      .txbyte_i  (txbyte),
      .sdi_i     (sdi_i),
      .sdo_o     (sdo_o),
      .rx_data_o (rx_data_o)
   );

endmodule

// File: rtl/reload_serial_port_checker.sv
module reload_serial_port_checker #(
   parameter int DATA_W = 8
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              busy_o,
   input logic              done_o,
   input logic              sclk_o,
   input logic              sdo_o,
   input logic [DATA_W-1:0] rx_data_o
);

   AST_IDLE_CLK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_o |-> !sclk_o); // R6

   AST_DONE_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> !busy_o); // R6

   AST_DONE_CLEARED_ON_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(busy_o) |-> !done_o); // R6

   AST_HIGH_HALF_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(sclk_o) |=> $stable(sclk_o)); // R2

   AST_LOW_HALF_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($fell(sclk_o) && busy_o) |=> $stable(sclk_o)); // R2

   AST_SDO_STILL_AT_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(sclk_o) |-> $stable(sdo_o)); // R4

   AST_SDO_STILL_WHILE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sclk_o && $past(sclk_o)) |-> $stable(sdo_o)); // R4

   AST_RX_HELD_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && $past(busy_o)) |-> $stable(rx_data_o)); // R5

endmodule

bind reload_serial_port reload_serial_port_checker #(
   .DATA_W (DATA_W)
) chk_i (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .busy_o    (busy_o),
   .done_o    (done_o),
   .sclk_o    (sclk_o),
   .sdo_o     (sdo_o),
   .rx_data_o (rx_data_o)
);

// File: tb/reload_serial_port_tb_top.sv
module reload_serial_port_tb_top;

   localparam int DATA_W = 8;
   localparam int CNT_W  = 8;
   localparam int WATCHDOG_CYCLES = 150000;

   typedef struct {
      logic [7:0] tx;
      logic [7:0] rx;
      int         first_half;
      int         rest_half;
      string      tag;
   } exp_t;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             wr_en = 1'b0;
   logic             wr_sel = 1'b0;
   logic [7:0]       wr_data = '0;
   logic             start = 1'b0;
   logic             busy, done, sclk, sdo;
   logic [7:0]       rx_data;
   logic             sdi;

   logic [7:0]       slave_byte = 8'h00;
   int               slave_idx  = 7;

   int               checks = 0;
   int               errors = 0;
   int               transfers_seen = 0;
   exp_t             sb_q[$];

   always #5 clk = ~clk;

   reload_serial_port #(
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W)
   ) dut_i (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .wr_en_i   (wr_en),
      .wr_sel_i  (wr_sel),
      .wr_data_i (wr_data),
      .start_i   (start),
      .busy_o    (busy),
      .done_o    (done),
      .rx_data_o (rx_data),
      .sclk_o    (sclk),
      .sdo_o     (sdo),
      .sdi_i     (sdi)
   );

   // peripheral model: next bit after each falling serial clock edge
   always @(negedge sclk) if (slave_idx > 0) slave_idx = slave_idx - 1;
   assign sdi = slave_byte[slave_idx];

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)",
                  req, what, act, act, exp, exp);
      end
   endtask

   task automatic reg_write(input logic sel, input logic [7:0] val);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = val;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pulse_start();
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   function automatic int half_of(input int n);
      return (n == 0) ? 257 : n + 1;
   endfunction

   // driver: program, push the expectation, launch; optional mid-transfer stimulus
   task automatic run_xfer(input logic [7:0] tx, input logic [7:0] peer,
                           input int reload, input int mid_reload,
                           input bit poke_busy, input string tag);
      exp_t e;
      reg_write(1'b0, 8'(reload));
      reg_write(1'b1, tx);
      slave_byte = peer;
      slave_idx  = 7;
      e.tx = tx; e.rx = peer; e.tag = tag;
      e.first_half = half_of(reload);
      e.rest_half  = (mid_reload >= 0) ? half_of(mid_reload) : half_of(reload);
      sb_q.push_back(e);
      pulse_start();
      if (mid_reload >= 0) begin
         repeat (2) @(negedge clk);
         reg_write(1'b0, 8'(mid_reload));       // R7
      end
      if (poke_busy) begin
         repeat (5) @(negedge clk);
         reg_write(1'b1, ~tx);                  // R9
         pulse_start();                         // R8
         repeat (7) @(negedge clk);
         pulse_start();                         // R8
      end
      while (busy) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   // monitor: times every serial clock edge and pops the scoreboard
   initial begin
      forever begin
         exp_t e;
         int   idx, last_t, n_edges;
         bit   prev, timing_ok, got_exp;
         logic [7:0] bits;
         @(negedge clk);
         if (rst_n && busy) begin
            transfers_seen++;
            got_exp = (sb_q.size() > 0);
            check(got_exp, "R8", "unexpected transfer started", 1, 0);
            if (got_exp) e = sb_q.pop_front();
            check(done == 1'b0, "R6", "done cleared at start", done, 0);
            idx = 0; last_t = 0; n_edges = 0; prev = 1'b0;
            timing_ok = 1'b1; bits = '0;
            while (busy) begin
               @(negedge clk);
               idx++;
               if (sclk != prev) begin
                  if (got_exp) begin
                     if (n_edges == 0 && idx != e.first_half) begin
                        timing_ok = 1'b0;
                        $display("FAIL %s first edge at clock %0d expected %0d",
                                 e.tag, idx, e.first_half);
                     end
                     if (n_edges > 0 && (idx - last_t) != e.rest_half) begin
                        timing_ok = 1'b0;
                        $display("FAIL %s edge %0d spacing %0d expected %0d",
                                 e.tag, n_edges, idx - last_t, e.rest_half);
                     end
                  end
                  if (sclk) bits = {bits[6:0], sdo};
                  n_edges++;
                  last_t = idx;
                  prev = sclk;
               end
            end
            if (got_exp) begin
               check(timing_ok, e.tag, "edge timing (see lines above)", 0, 0);
               check(n_edges == 16, "R6", "sclk toggles per byte", n_edges, 16);
               check(sclk == 1'b0 && done == 1'b1, "R6", "idle low with done",
                     {sclk, done}, 2'b01);
               check(bits == e.tx, "R4", "bits on sdo", bits, e.tx);
               check(rx_data == e.rx, "R5", "received byte", rx_data, e.rx);
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (WATCHDOG_CYCLES) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired: actual %0d cycles expected fewer", WATCHDOG_CYCLES);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(sclk == 1'b0, "R1", "sclk in reset", sclk, 0);
      check(busy == 1'b0, "R1", "busy in reset", busy, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(sdo == 1'b0, "R1", "sdo after reset", sdo, 0);
      check(done == 1'b0, "R1", "done after reset", done, 0);
      check(rx_data == 8'h00, "R1", "rx_data after reset", rx_data, 0);

      run_xfer(8'hA5, 8'h3C, 1,   -1, 1'b0, "R2_min_rate");
      run_xfer(8'h81, 8'h7E, 2,   -1, 1'b0, "R2_reload2");
      run_xfer(8'h00, 8'hFF, 4,   -1, 1'b0, "R2_reload4");
      run_xfer(8'h5A, 8'hC3, 0,   -1, 1'b0, "R3_zero_reload");
      run_xfer(8'hE7, 8'h18, 10,   3, 1'b0, "R7_mid_reload");
      run_xfer(8'h96, 8'h69, 3,   -1, 1'b1, "R8_R9_busy_pokes");
      check(busy == 1'b0, "R8", "no restart after ignored start", busy, 0);
      run_xfer(8'h01, 8'h80, 255, -1, 1'b0, "R2_reload255");

      repeat (5) @(negedge clk);
      check(sb_q.size() == 0, "R8", "scoreboard drained", sb_q.size(), 0);
      check(transfers_seen == 7, "R8", "transfer count", transfers_seen, 7);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule